// File: doc/BRIEF.md
# Fast Reciprocal Square Root Unit

This unit returns an approximation of 1/sqrt(x) for a single-precision floating-point operand. A single-precision word holds one sign bit, an 8-bit exponent with a bias of 127 and a 23-bit fraction with an implied leading one. Its value is (-1)^s × (1 + F/2^23) × 2^(E-127).

The unit makes a first guess with integer arithmetic. It shifts the input word right by one bit and subtracts the result from a constant wired into the logic. It then applies one Newton-Raphson correction, y1 = y0 × (1.5 − 0.5 × x × y0²), built from truncating floating-point multipliers and a fixed-point subtraction.

The unit is fully pipelined and the result comes from an output register. It takes one operand per clock with a valid strobe and produces the matching result with its own strobe exactly three clocks later. Zero, infinity, negative and not-a-number operands get fixed result codes.

Top module: `frsr_unit`

## Requirements
- R1: For a positive normal operand, the result is a positive normal word: bit 31 is 0 and the exponent field (bits 30:23) lies between 1 and 254.
- R2: The first guess y0 is the constant 0x5F375A86 minus the operand word logically shifted right by one bit. Both values are treated as unsigned 32-bit integers, and the shift puts a 0 into bit 31.
- R3: For a positive normal operand, the result is within a relative error of 1e-5 of y0 × (1.5 − 0.5 × x × y0²), evaluated exactly with y0 taken from R2.
- R4: For a positive normal operand, the result is within a relative error of 2e-3 of the true 1/sqrt(x).
- R5: An operand accepted at a clock edge with in_valid high produces out_valid high after the third following edge. Operands may arrive on every clock.
- R6: out_valid is never high without a matching accepted operand, and results leave in the order the operands arrived.
- R7: An operand with exponent field 0, of either sign, returns 0x7F800000 (positive infinity).
- R8: A negative operand that is not zero, including negative infinity, returns 0x7FC00000. Any operand with exponent field 255 and a nonzero fraction also returns 0x7FC00000.
- R9: The operand 0x7F800000 (positive infinity) returns 0x00000000.
- R10: While rst is high at a clock edge, all pipeline valid bits are cleared. Operands in flight are dropped and out_valid is low after that edge.
- R11: In any cycle without a completing result, out_y keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand strobe |
| in_x | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, three clocks after the operand |
| out_y | output | 32 | Single-precision approximation of 1/sqrt(in_x) |

## Verification
The bench builds the unit with its default parameter, so the seed constant is 0x5F375A86. With that constant the seed-based reference of R3 and the 2e-3 bound of R4 can both be checked for every positive normal operand. This includes the smallest and largest normal values, where an intermediate product lies near the edge of the exponent range. Back-to-back and gapped operand streams, every special operand class and a reset in mid-flight are all run against a queue of expected results.

// File: rtl/frsr_pkg.sv
package frsr_pkg;

    localparam int WORD_W   = 32;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int PROD_W   = 2 * SIG_W;
    localparam int BIAS     = 127;
    localparam int FIX_W    = SIG_W + 2;

    localparam logic [WORD_W-1:0] SEED_MAGIC = 32'h5F37_5A86;
    localparam logic [WORD_W-1:0] POS_INF    = 32'h7F80_0000;
    localparam logic [WORD_W-1:0] QUIET_NAN  = 32'h7FC0_0000;
    localparam logic [WORD_W-1:0] POS_ZERO   = 32'h0000_0000;
    localparam logic [FIX_W-1:0]  THREE_HALVES = FIX_W'(3) << (SIG_W - 1);

    typedef enum logic [1:0] {
        CLS_NORM,
        CLS_ZERO,
        CLS_INF,
        CLS_NAN
    } frsr_cls_e;

    typedef struct packed {
        frsr_cls_e          cls;
        logic [WORD_W-1:0]  x;
        logic [WORD_W-1:0]  y0;
    } seed_stage_t;

    typedef struct packed {
        frsr_cls_e          cls;
        logic [WORD_W-1:0]  y0;
        logic [WORD_W-1:0]  h;
    } refine_stage_t;

    // Truncating multiply of two positive normal words.
    function automatic logic [WORD_W-1:0] fp_mul(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
        logic [PROD_W-1:0]  pr;
        logic signed [10:0] e;
        logic [FRAC_W-1:0]  m;
        pr = {{SIG_W{1'b0}}, 1'b1, a[FRAC_W-1:0]} * {{SIG_W{1'b0}}, 1'b1, b[FRAC_W-1:0]};
        e  = $signed({3'b000, a[WORD_W-2:FRAC_W]}) + $signed({3'b000, b[WORD_W-2:FRAC_W]})
             - 11'sd127;
        if (pr[PROD_W-1]) begin
            m = pr[PROD_W-2 -: FRAC_W];
            e = e + 11'sd1;
        end else begin
            m = pr[PROD_W-3 -: FRAC_W];
        end
        if (a[WORD_W-2:FRAC_W] == '0 || b[WORD_W-2:FRAC_W] == '0 || e <= 11'sd0)
            return POS_ZERO;
        else if (e >= 11'sd255)
            return POS_INF;
        else
            return {1'b0, e[EXP_W-1:0], m};
    endfunction

    // Position of the highest set bit of a fixed-point value.
    function automatic logic [4:0] msb_index(input logic [FIX_W-1:0] v);
        logic [4:0] p;
        p = '0;
        for (int i = 0; i < FIX_W; i++)
            if (v[i]) p = 5'(i);
        return p;
    endfunction

endpackage

// File: rtl/frsr_seed.sv
module frsr_seed
    import frsr_pkg::*;
#(
    parameter logic [31:0] SEED_CONST = SEED_MAGIC
) (
    input  logic [WORD_W-1:0] x,
    output frsr_cls_e         cls,
    output logic [WORD_W-1:0] y0
);
    logic [EXP_W-1:0]  ex;
    logic [WORD_W-1:0] half_word;

    assign ex        = x[WORD_W-2:FRAC_W];
    assign half_word = {1'b0, x[WORD_W-1:1]};
    assign y0        = SEED_CONST - half_word;

    always_comb begin
        if (ex == '0)
            cls = CLS_ZERO;
        else if (ex == '1 && x[FRAC_W-1:0] != '0)
            cls = CLS_NAN;
        else if (x[WORD_W-1])
            cls = CLS_NAN;
        else if (ex == '1)
            cls = CLS_INF;
        else
            cls = CLS_NORM;
    end
endmodule

// File: rtl/frsr_fmul.sv
module frsr_fmul
    import frsr_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] p
);
    assign p = fp_mul(a, b);
endmodule

// File: rtl/frsr_tail.sv
module frsr_tail
    import frsr_pkg::*;
(
    input  logic [WORD_W-1:0] h,
    output logic [WORD_W-1:0] r
);
    logic [EXP_W-1:0] he;
    logic [EXP_W-1:0] sh;
    logic [FIX_W-1:0] hfix;
    logic [FIX_W-1:0] rfix;
    logic [FIX_W-1:0] aligned;
    logic [4:0]       lead;

    assign he = h[WORD_W-2:FRAC_W];
    assign sh = 8'd126 - he;

    always_comb begin
        if (he == '0)
            hfix = '0;
        else if (he > 8'd126)
            hfix = THREE_HALVES;
        else if (sh > 8'd25)
            hfix = '0;
        else
            hfix = {2'b00, 1'b1, h[FRAC_W-1:0]} >> sh;
    end

    assign rfix    = THREE_HALVES - hfix;
    assign lead    = msb_index(rfix);
    assign aligned = rfix << (5'd25 - lead);

    always_comb begin
        if (rfix == '0)
            r = POS_ZERO;
        else
            r = {1'b0, 8'd103 + {3'b000, lead}, aligned[FIX_W-2 -: FRAC_W]};
    end
endmodule

// File: rtl/frsr_unit.sv
module frsr_unit
    import frsr_pkg::*;
#(
    parameter logic [31:0] SEED_CONST = SEED_MAGIC
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_x,
    output logic        out_valid,
    output logic [31:0] out_y
);
    frsr_cls_e         cls_c;
    logic [WORD_W-1:0] y0_c;
    logic [WORD_W-1:0] xy_c;
    logic [WORD_W-1:0] xyy_c;
    logic [WORD_W-1:0] h_c;
    logic [WORD_W-1:0] r_c;
    logic [WORD_W-1:0] y1_c;

    logic          s1_v;
    logic          s2_v;
    seed_stage_t   s1;
    refine_stage_t s2;

    // Stage 1: classification and integer seed
    frsr_seed #(.SEED_CONST(SEED_CONST)) u_seed (
        .x   (in_x),
        .cls (cls_c),
        .y0  (y0_c)
    );

    always_ff @(posedge clk) begin
        if (rst) s1_v <= 1'b0;
        else     s1_v <= in_valid;
        if (in_valid) s1 <= '{cls: cls_c, x: in_x, y0: y0_c};
    end

    // Stage 2: x*y0*y0, then halve
    frsr_fmul u_mul_xy  (.a(s1.x), .b(s1.y0), .p(xy_c));
    frsr_fmul u_mul_xyy (.a(xy_c), .b(s1.y0), .p(xyy_c));

    assign h_c = (xyy_c[WORD_W-2:FRAC_W] > 8'd1)
               ? {1'b0, xyy_c[WORD_W-2:FRAC_W] - 8'd1, xyy_c[FRAC_W-1:0]}
               : POS_ZERO;

    always_ff @(posedge clk) begin
        if (rst) s2_v <= 1'b0;
        else     s2_v <= s1_v;
        if (s1_v) s2 <= '{cls: s1.cls, y0: s1.y0, h: h_c};
    end

    // Stage 3: 1.5 - h, final multiply, special codes
    frsr_tail u_tail (.h(s2.h), .r(r_c));
    frsr_fmul u_mul_fin (.a(s2.y0), .b(r_c), .p(y1_c));

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= s2_v;
        if (s2_v) begin
            unique case (s2.cls)
                CLS_ZERO: out_y <= POS_INF;
                CLS_INF:  out_y <= POS_ZERO;
                CLS_NAN:  out_y <= QUIET_NAN;
                default:  out_y <= y1_c;
            endcase
        end
    end

    assert_rst_clear_R10: assert property (@(posedge clk)
        rst |=> (!s1_v && !s2_v && !out_valid));

    assert_stage1_adv_R5: assert property (@(posedge clk) disable iff (rst)
        s1_v |=> s2_v);

    assert_stage2_adv_R5: assert property (@(posedge clk) disable iff (rst)
        s2_v |=> out_valid);

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        !s2_v |=> !out_valid);

    assert_zero_inf_R7: assert property (@(posedge clk) disable iff (rst)
        (s2_v && s2.cls == CLS_ZERO) |=> (out_y == POS_INF));

    assert_neg_nan_R8: assert property (@(posedge clk) disable iff (rst)
        (s2_v && s2.cls == CLS_NAN) |=> (out_y == QUIET_NAN));

    assert_inf_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (s2_v && s2.cls == CLS_INF) |=> (out_y == POS_ZERO));

    assert_positive_R1: assert property (@(posedge clk) disable iff (rst)
        (s2_v && s2.cls == CLS_NORM) |=> (!out_y[31] && out_y[30:23] != 8'd0
                                          && out_y[30:23] != 8'hFF));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !s2_v |=> $stable(out_y));
endmodule

// File: tb/tb_frsr_unit.sv
module tb_frsr_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_x;
    logic        out_valid;
    logic [31:0] out_y;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] x;
        int          t;
    } item_t;
    item_t q[$];

    logic [31:0] last_y;
    bit          have_last = 1'b0;

    frsr_unit dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_x      (in_x),
        .out_valid (out_valid),
        .out_y     (out_y)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic real w2r(input logic [31:0] w);
        real m;
        real s;
        int  e;
        m = 1.0 + real'(w[22:0]) / 8388608.0;
        e = int'(w[30:23]) - 127;
        s = 1.0;
        if (e >= 0) for (int i = 0; i < e; i++)  s = s * 2.0;
        else        for (int i = 0; i < -e; i++) s = s / 2.0;
        return m * s;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] x,
                         input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s x=%h actual=%h expected=%h", req, x, act, exp_v);
        end
    endtask

    task automatic check_value(input logic [31:0] x, input logic [31:0] y);
        real xr, yr, y0r, nr, tr, e1, e2;
        logic [31:0] y0;
        if (x[30:23] == 8'd0) begin
            check(y == 32'h7F800000, "R7", x, y, 32'h7F800000);
        end else if (x[31] || (x[30:23] == 8'hFF && x[22:0] != 0)) begin
            check(y == 32'h7FC00000, "R8", x, y, 32'h7FC00000);
        end else if (x[30:23] == 8'hFF) begin
            check(y == 32'h00000000, "R9", x, y, 32'h00000000);
        end else begin
            check(!y[31] && y[30:23] != 0 && y[30:23] != 8'hFF, "R1", x, y, 32'h0);
            xr  = w2r(x);
            yr  = w2r(y);
            y0  = 32'h5F375A86 - {1'b0, x[31:1]};
            y0r = w2r(y0);
            nr  = y0r * (1.5 - 0.5 * xr * y0r * y0r);
            e1  = (yr - nr) / nr;
            if (e1 < 0.0) e1 = -e1;
            check(e1 < 1.0e-5, "R2/R3", x, y, y0);
            tr  = 1.0 / $sqrt(xr);
            e2  = (yr - tr) / tr;
            if (e2 < 0.0) e2 = -e2;
            check(e2 < 2.0e-3, "R4", x, y, 32'h0);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R6", 32'h0, out_y, 32'h0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(cyc == it.t + 3, "R5", it.x, 32'(cyc), 32'(it.t + 3));
                    check_value(it.x, out_y);
                end
                last_y    = out_y;
                have_last = 1'b1;
            end else begin
                if (q.size() > 0 && q[0].t + 3 <= cyc) begin
                    check(1'b0, "R5", q[0].x, 32'(cyc), 32'(q[0].t + 3));
                    void'(q.pop_front());
                end
                if (have_last)
                    check(out_y == last_y, "R11", 32'h0, out_y, last_y);
            end
        end
    end

    task automatic push(input logic [31:0] v);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = v;
        it.x = v;
        it.t = cyc;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_x     = 32'hDEADBEEF;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [31:0] lfsr = 32'hACE1_2468;

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_x     = 32'h0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10", 32'h0, {31'b0, out_valid}, 32'h0);
        rst = 1'b0;

        // back-to-back directed operands (R5 throughput, R2/R3/R4)
        push(32'h3F800000);
        push(32'h40800000);
        push(32'h40000000);
        push(32'h3E800000);
        push(32'h42C80000);
        push(32'h00800000);
        push(32'h7F7FFFFF);
        push(32'h0DA24260);
        push(32'h7E967699);
        idle(2);

        // gapped operands (R6, R11)
        push(32'h41100000);
        idle(3);
        push(32'h3DCCCCCD);
        idle(5);

        // special classes (R7, R8, R9)
        push(32'h00000000);
        push(32'h80000000);
        push(32'h00000123);
        push(32'hBF800000);
        push(32'hFF800000);
        push(32'h7F800000);
        push(32'h7FC00001);
        push(32'hFFC00000);
        idle(4);

        // random positive normals, mixed with gaps
        for (int i = 0; i < 300; i++) begin
            logic [7:0] e;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            e = 8'd1 + 8'(lfsr[31:24] % 8'd254);
            push({1'b0, e, lfsr[22:0]});
            if (lfsr[3:0] == 4'd0) idle(2);
        end
        idle(5);

        // reset in mid-flight drops in-flight operands (R10)
        push(32'h3F800000);
        push(32'h40800000);
        @(negedge clk);
        rst       = 1'b1;
        in_valid  = 1'b0;
        q.delete();
        have_last = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R10", 32'h0, {31'b0, out_valid}, 32'h0);
        @(negedge clk);
        check(out_valid == 1'b0, "R10", 32'h0, {31'b0, out_valid}, 32'h0);
        rst = 1'b0;
        idle(6);

        // operation resumes after reset
        push(32'h40800000);
        idle(6);

        check(q.size() == 0, "R6", 32'h0, 32'(q.size()), 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule